// File: doc/BRIEF.md
# Quadrature Clock Phase Calibration Controller

This block tunes the 5-bit delay code that places the quadrature clock of a receiver demodulator a quarter period after the in-phase clock. It decides when a calibration run takes place and times each run at 65 oscillator cycles. During the run it searches the delay code against a single comparator bit that comes back from the analog phase detector. When the run ends it publishes the resulting code, along with a flag that marks a phase shift larger than half a period.

Runs can start from three sources. The first is the end of the reset sequence, which always starts a run. The second is the end of each transceive operation, which starts a run only while the control bit `auto_off` is low. The third is a rising edge on `auto_off`, which starts a run. Software may also load the delay code directly. Such a value stays in place only while `auto_off` is high. While `auto_off` is low, the next run after a transceive replaces it. A trigger that arrives during a run is held as one pending request and is served as soon as the run finishes.

Top module: `qclk_cal_ctrl`

## Requirements
- R1: While reset is asserted, `dly_code` is 0, `over_half` is 0 and `cal_busy` is 0. After reset is released, a run starts without any further stimulus, whatever the level of `auto_off`.
- R2: With `auto_off` at 0, a one-cycle pulse on `xcv_done` while idle sets `cal_busy` high from the next clock edge.
- R3: With `auto_off` at 1 and no rising edge on it, `xcv_done` starts no run and leaves `dly_code` unchanged.
- R4: A 0-to-1 change on `auto_off` while idle sets `cal_busy` high from the next clock edge. A 1-to-0 change starts nothing.
- R5: `cal_busy` stays high for exactly 65 consecutive clock cycles per run.
- R6: The search tests bits MSB first, one bit every 8 cycles. `dly_tap` is 16 in the first cycle of a run. The comparator input `phase_ok` = 1 means the tap under test does not exceed the target phase. The final `dly_code` is the largest code for which the comparator reads 1, and it appears when `cal_busy` falls. While idle, `dly_tap` equals `dly_code`.
- R7: At the end of a run, `over_half` becomes 1 when the new code is 16 or more (a phase beyond 180 degrees) and 0 otherwise.
- R8: A write (`dly_wr_en`=1) while idle loads `dly_wr_data` into `dly_code` at the next edge. A write while `cal_busy` is 1 is ignored. Writes leave `over_half` unchanged.
- R9: Triggers that arrive during a run cause exactly one further run. `cal_busy` is low for exactly one cycle between the two runs.
- R10: A written code survives `xcv_done` while `auto_off` is 1. While `auto_off` is 0, the run started by the next `xcv_done` replaces it. A write and a start in the same idle cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xcv_done | input | 1 | One-cycle pulse at the end of a transceive operation |
| auto_off | input | 1 | 1 suppresses automatic runs after transceive; a rising edge starts a run |
| dly_wr_en | input | 1 | Software write strobe for the delay code |
| dly_wr_data | input | 5 | Delay code to write |
| phase_ok | input | 1 | Phase comparator: 1 when the tap under test is not beyond the target |
| dly_tap | output | 5 | Code driving the delay line (trial code during a run) |
| dly_code | output | 5 | Calibrated or written delay code |
| over_half | output | 1 | Phase shift exceeds 180 degrees |
| cal_busy | output | 1 | High while a calibration run is in progress |

## Verification
Two collisions need checking. The first is a software write landing in the same idle cycle as a transceive trigger. The bench drives both strobes on one negative edge and checks that `dly_code` shows the written value while `cal_busy` is already high. It then checks that the code at the end of the run is the search result. The second is a trigger arriving while a run is still going. The bench pulses `xcv_done` twice in the middle of a run and checks that `cal_busy` drops for exactly one cycle, rises for a single further run, and then stays low.

// File: rtl/qcal_pkg.sv
package qcal_pkg;
  localparam int CODE_W   = 5;
  localparam int RUN_CYC  = 65;
  localparam int STEP_CYC = 8;
endpackage

// File: rtl/qcal_rst_sync.sv
module qcal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/qcal_trig.sv
module qcal_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic xcv_done,
  input  logic auto_off,
  input  logic busy,
  output logic start,
  output logic pend
);
  logic off_q, off_d;
  logic pend_q, pend_d;
  logic rise, req;

  always_comb begin
    rise   = auto_off & ~off_q;
    req    = (xcv_done & ~auto_off) | rise;
    start  = ~busy & (pend_q | req);
    off_d  = auto_off;
    pend_d = start ? 1'b0 : (pend_q | req);
  end

  // pend resets to 1 so that the post-reset run always happens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      off_q  <= off_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R4: an edge on the control bit seen while idle leads to a busy run
  a_r4_edge_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_off && !off_q && !busy) |=> busy);

  // R9: a pending request is never held while idle for more than the start cycle
  a_r9_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |=> (busy && !pend_q) || pend_q == 1'b0);
endmodule

// File: rtl/qcal_sar.sv
module qcal_sar
  import qcal_pkg::*;
#(
  parameter int W     = CODE_W,
  parameter int RUN   = RUN_CYC,
  parameter int STEP  = STEP_CYC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         phase_ok,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic [W-1:0] code,
  output logic [W-1:0] tap,
  output logic         flag
);
  localparam int CNT_W = $clog2(RUN);
  localparam int STP_W = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN - 1);
  localparam logic [STP_W-1:0] STEP_END = STP_W'(STEP - 1);
  localparam logic [W-1:0]     TOP_BIT  = {1'b1, {(W-1){1'b0}}};

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [STP_W-1:0] stp_q, stp_d;
  logic [W-1:0]     trial_q, trial_d;
  logic [W-1:0]     mask_q, mask_d;
  logic [W-1:0]     code_q, code_d;
  logic             flag_q, flag_d;
  logic             last, eval;
  logic             code_en, run_en;

  always_comb begin
    last    = busy_q && (cnt_q == LAST_CNT);
    eval    = busy_q && (stp_q == STEP_END) && (mask_q != '0);
    run_en  = start || busy_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    stp_d   = stp_q;
    trial_d = trial_q;
    mask_d  = mask_q;
    if (start) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      stp_d   = '0;
      trial_d = TOP_BIT;
      mask_d  = TOP_BIT;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      stp_d = (stp_q == STEP_END) ? '0 : stp_q + 1'b1;
      if (last) busy_d = 1'b0;
      if (eval) begin
        trial_d = (phase_ok ? trial_q : (trial_q & ~mask_q)) | (mask_q >> 1);
        mask_d  = mask_q >> 1;
      end
    end
  end

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    flag_d  = flag_q;
    if (last) begin
      code_en = 1'b1;
      code_d  = trial_q;
      flag_d  = trial_q[W-1];
    end else if (wr_en && !busy_q) begin
      code_en = 1'b1;
      code_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      stp_q   <= '0;
      trial_q <= '0;
      mask_q  <= '0;
    end else if (run_en) begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      stp_q   <= stp_d;
      trial_q <= trial_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else if (code_en) begin
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  assign busy = busy_q;
  assign code = code_q;
  assign flag = flag_q;
  assign tap  = busy_q ? trial_q : code_q;

  // R5: busy cannot drop before the final count
  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST_CNT) |=> busy_q);

  // R5: busy always drops after the final count
  a_r5_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);

  // R8: the published code is frozen during a run except on its final cycle
  a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> $stable(code_q));

  // R6: at most one bit remains under test
  a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
endmodule

// File: rtl/qclk_cal_ctrl.sv
module qclk_cal_ctrl
  import qcal_pkg::*;
#(
  parameter int W    = CODE_W,
  parameter int RUN  = RUN_CYC,
  parameter int STEP = STEP_CYC
) (
  input  logic         clk_osc,
  input  logic         rst_n,
  input  logic         xcv_done,
  input  logic         auto_off,
  input  logic         dly_wr_en,
  input  logic [W-1:0] dly_wr_data,
  input  logic         phase_ok,
  output logic [W-1:0] dly_tap,
  output logic [W-1:0] dly_code,
  output logic         over_half,
  output logic         cal_busy
);
  logic rst_sn;
  logic start;
  logic pend;

  qcal_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  qcal_trig u_trig (
    .clk      (clk_osc),
    .rst_n    (rst_sn),
    .xcv_done (xcv_done),
    .auto_off (auto_off),
    .busy     (cal_busy),
    .start    (start),
    .pend     (pend)
  );

  qcal_sar #(.W(W), .RUN(RUN), .STEP(STEP)) u_sar (
    .clk      (clk_osc),
    .rst_n    (rst_sn),
    .start    (start),
    .phase_ok (phase_ok),
    .wr_en    (dly_wr_en),
    .wr_data  (dly_wr_data),
    .busy     (cal_busy),
    .code     (dly_code),
    .tap      (dly_tap),
    .flag     (over_half)
  );

  // R2: end of transceive with automatic runs enabled starts a run
  a_r2_xcv_start: assert property (@(posedge clk_osc) disable iff (!rst_sn)
    (!cal_busy && xcv_done && !auto_off) |=> cal_busy);

  // R3: end of transceive is ignored while automatic runs are disabled
  a_r3_xcv_blocked: assert property (@(posedge clk_osc) disable iff (!rst_sn)
    (!cal_busy && !pend && xcv_done && auto_off && $past(auto_off)) |=> !cal_busy);

  // R7: the flag agrees with the half-range of the code produced by the run
  a_r7_flag_match: assert property (@(posedge clk_osc) disable iff (!rst_sn)
    $fell(cal_busy) |-> (over_half == dly_code[W-1]));

  // R6: idle tap follows the published code
  a_r6_idle_tap: assert property (@(posedge clk_osc) disable iff (!rst_sn)
    !cal_busy |-> (dly_tap == dly_code));
endmodule

// File: tb/sim_qclk_cal_ctrl.sv
module sim_qclk_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // each entry: {target phase code, expected code, expected flag}
  localparam logic [10:0] VEC [NV] = '{
    {5'd0,  5'd0,  1'b0},
    {5'd31, 5'd31, 1'b1},
    {5'd16, 5'd16, 1'b1},
    {5'd15, 5'd15, 1'b0},
    {5'd10, 5'd10, 1'b0},
    {5'd21, 5'd21, 1'b1}
  };

  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic       xcv_done;
  logic       auto_off;
  logic       dly_wr_en;
  logic [4:0] dly_wr_data;
  logic       phase_ok;
  logic [4:0] dly_tap;
  logic [4:0] dly_code;
  logic       over_half;
  logic       cal_busy;
  logic [4:0] target;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  // behavioural phase detector
  assign phase_ok = (dly_tap <= target);

  qclk_cal_ctrl u0 (
    .clk_osc     (clk_osc),
    .rst_n       (rst_n),
    .xcv_done    (xcv_done),
    .auto_off    (auto_off),
    .dly_wr_en   (dly_wr_en),
    .dly_wr_data (dly_wr_data),
    .phase_ok    (phase_ok),
    .dly_tap     (dly_tap),
    .dly_code    (dly_code),
    .over_half   (over_half),
    .cal_busy    (cal_busy)
  );

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_busy(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk_osc);
      if (cal_busy) seen = 1'b1;
    end
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (cal_busy && n < 300) begin
      n++;
      @(negedge clk_osc);
    end
  endtask

  task automatic pulse_xcv();
    xcv_done = 1'b1;
    @(negedge clk_osc);
    xcv_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    logic [4:0] hold;
    rst_n = 1'b0; xcv_done = 1'b0; auto_off = 1'b0;
    dly_wr_en = 1'b0; dly_wr_data = '0; target = 5'd13;
    repeat (3) @(negedge clk_osc);
    check("R1 reset code", dly_code, 0);
    check("R1 reset flag", over_half, 0);
    check("R1 reset busy", cal_busy, 0);
    rst_n = 1'b1;
    wait_busy(seen);
    check("R1 post-reset run (auto_off=0)", seen, 1);
    check("R6 first tap", dly_tap, 16);
    run_len(n);
    check("R5 run length", n, 65);
    check("R6 code after reset run", dly_code, 13);
    check("R7 flag after reset run", over_half, 0);

    // second reset with automatic runs disabled
    rst_n = 1'b0; auto_off = 1'b1; target = 5'd20;
    repeat (2) @(negedge clk_osc);
    rst_n = 1'b1;
    wait_busy(seen);
    check("R1 post-reset run (auto_off=1)", seen, 1);
    run_len(n);
    check("R6 code (auto_off=1 reset)", dly_code, 20);
    check("R7 flag set", over_half, 1);

    // falling edge on auto_off starts nothing
    auto_off = 1'b0;
    @(negedge clk_osc);
    @(negedge clk_osc);
    check("R4 falling edge idle", cal_busy, 0);

    // vector table walked via transceive triggers
    foreach (VEC[k]) begin
      target = VEC[k][10:6];
      pulse_xcv();
      check("R2 xcv starts run", cal_busy, 1);
      check("R6 first trial tap", dly_tap, 16);
      run_len(n);
      check("R5 run length", n, 65);
      check("R6 search result", dly_code, VEC[k][5:1]);
      check("R7 half flag", over_half, VEC[k][0]);
      check("R6 idle tap", dly_tap, VEC[k][5:1]);
    end

    // R9: triggers during a run give exactly one extra run
    target = 5'd7;
    pulse_xcv();
    repeat (10) @(negedge clk_osc);
    pulse_xcv();
    repeat (20) @(negedge clk_osc);
    pulse_xcv();
    run_len(n);
    check("R9 gap cycle low", cal_busy, 0);
    @(negedge clk_osc);
    check("R9 extra run starts", cal_busy, 1);
    run_len(n);
    check("R9 extra run length", n, 65);
    repeat (5) @(negedge clk_osc);
    check("R9 only one extra run", cal_busy, 0);

    // R4: rising edge starts a run
    target = 5'd25;
    auto_off = 1'b1;
    @(negedge clk_osc);
    check("R4 rising edge starts", cal_busy, 1);
    run_len(n);
    check("R4 run result", dly_code, 25);

    // R8 idle write, R3 and R10 persistence with auto_off=1
    dly_wr_en = 1'b1; dly_wr_data = 5'd9;
    @(negedge clk_osc);
    dly_wr_en = 1'b0;
    check("R8 idle write", dly_code, 9);
    check("R8 write keeps flag", over_half, 1);
    pulse_xcv();
    check("R3 xcv blocked", cal_busy, 0);
    repeat (4) @(negedge clk_osc);
    check("R3 still idle", cal_busy, 0);
    check("R10 written code kept", dly_code, 9);

    // R8: write during a run is ignored
    auto_off = 1'b0;
    @(negedge clk_osc);
    target = 5'd4;
    auto_off = 1'b1;
    @(negedge clk_osc);
    check("R4 second rising edge", cal_busy, 1);
    hold = dly_code;
    repeat (5) @(negedge clk_osc);
    dly_wr_en = 1'b1; dly_wr_data = 5'd3;
    @(negedge clk_osc);
    dly_wr_en = 1'b0;
    check("R8 busy write ignored", dly_code, hold);
    run_len(n);
    check("R8 run result after ignored write", dly_code, 4);
    check("R7 flag cleared", over_half, 0);

    // R10: collision of write and start, auto_off=0
    auto_off = 1'b0;
    @(negedge clk_osc);
    target = 5'd18;
    dly_wr_en = 1'b1; dly_wr_data = 5'd7; xcv_done = 1'b1;
    @(negedge clk_osc);
    dly_wr_en = 1'b0; xcv_done = 1'b0;
    check("R10 collision write taken", dly_code, 7);
    check("R10 collision run started", cal_busy, 1);
    run_len(n);
    check("R10 written code replaced", dly_code, 18);
    check("R7 flag after collision run", over_half, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule